// File: doc/BRIEF.md
# Add/Subtract Arithmetic Unit with Condition Flags

This block is the arithmetic core of a small bus-based processor. It takes two operands held in external registers and forms either their sum or their difference. Subtraction reuses the adder: the second operand is bit-inverted and a 1 is injected as the first carry-in, which gives two's-complement subtraction. The datapath is a ripple chain of full adders, and each full adder is built from two half adders. The result is combinational from the operands and the subtract control.

The result reaches the shared bus only while the bus output enable is high. The bus is modelled as a data/valid pair. Two condition signals come out of the arithmetic: the raw carry from the top slice and a zero indication. A separate two-bit flags register captures both on a load strobe. The control logic then uses the captured bits for jump-if-zero and jump-if-carry decisions.

Top module: `addsub_flags_unit`

## Requirements
- R1: With `sub_en`=0 the result equals (`opa` + `opb`) modulo 2^W, in the same cycle as the inputs.
- R2: With `sub_en`=1 the result equals (`opa` − `opb`) modulo 2^W, in the same cycle as the inputs.
- R3: `carry_out` is the carry leaving the most significant slice. It is 1 for an addition when `opa`+`opb` ≥ 2^W. It is 1 for a subtraction when `opa` ≥ `opb`, which means "no borrow", and it is never inverted.
- R4: `zero_out` is 1 exactly when all W result bits are 0, in either mode.
- R5: With `bus_oe`=1, `bus_valid`=1 and `bus_data` carries the result. With `bus_oe`=0, `bus_valid`=0 and `bus_data` is all zeros.
- R6: On a rising clock edge with `flag_load`=1 and `rst`=0, `flag_carry` and `flag_zero` take the values that `carry_out` and `zero_out` had just before that edge.
- R7: On a rising clock edge with `flag_load`=0 and `rst`=0, `flag_carry` and `flag_zero` keep their values, whatever the operands do.
- R8: A rising edge with `rst`=1 clears both flags. Reset wins over a simultaneous `flag_load`.
- R9: The flags capture the combinational result of the same cycle. A load issued while the result is also driven to the bus records the flags of the value on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| sub_en | input | 1 | 1 selects subtraction, 0 selects addition |
| bus_oe | input | 1 | Puts the result on the bus |
| flag_load | input | 1 | Captures carry and zero into the flags register |
| bus_data | output | W | Result when driven, otherwise zero |
| bus_valid | output | 1 | High while the unit drives the bus |
| carry_out | output | 1 | Live carry from the top slice |
| zero_out | output | 1 | Live zero indication of the result |
| flag_carry | output | 1 | Stored carry flag |
| flag_zero | output | 1 | Stored zero flag |

## Verification
Driving the bus and loading the flags can happen in the same cycle, and so can a reset and a flag load. The bench raises `bus_oe` and `flag_load` together on carry-and-zero corner cases: 0x00−0x00, 0xFF+0x01 and 0x05−0x06. One cycle later it compares the stored flags with the value that was on the bus. It also holds `flag_load` high through reset and expects cleared flags. In a separate phase it changes the operands with the load low and expects the flags to stay unchanged.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef struct packed {
    logic carry;
    logic zero;
  } flags_t;

  // {carry, sum} of two single bits
  function automatic logic [1:0] half_add(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder
  import alu_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout
);
  logic [1:0] ha0;
  logic [1:0] ha1;

  always_comb begin
    ha0  = half_add(a, b);
    ha1  = half_add(ha0[0], cin);
    sum  = ha1[0];
    cout = ha0[1] | ha1[1];
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_en,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0]   chain;
  logic [W-1:0] b_eff;

  assign b_eff    = opb ^ {W{sub_en}};
  assign chain[0] = sub_en;

  for (genvar i = 0; i < W; i++) begin : g_slice
    alu_full_adder u_fa (
      .a    (opa[i]),
      .b    (b_eff[i]),
      .cin  (chain[i]),
      .sum  (sum[i]),
      .cout (chain[i+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic         is_zero
);
  assign is_zero = ~(|value);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_en,
  input  logic         bus_oe,
  input  logic         flag_load,
  output logic [W-1:0] bus_data,
  output logic         bus_valid,
  output logic         carry_out,
  output logic         zero_out,
  output logic         flag_carry,
  output logic         flag_zero
);
  logic [W-1:0] sum_w;
  logic         cout_w;
  logic         zero_w;
  flags_t       flags_d;
  flags_t       flags_q;

  alu_ripple #(.W(W)) u_ripple (
    .opa    (opa),
    .opb    (opb),
    .sub_en (sub_en),
    .sum    (sum_w),
    .cout   (cout_w)
  );

  alu_zero_detect #(.W(W)) u_zero (
    .value   (sum_w),
    .is_zero (zero_w)
  );

  assign flags_d.carry = cout_w;
  assign flags_d.zero  = zero_w;

  alu_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (flag_load),
    .d    (flags_d),
    .q    (flags_q)
  );

  assign bus_data   = bus_oe ? sum_w : '0;
  assign bus_valid  = bus_oe;
  assign carry_out  = cout_w;
  assign zero_out   = zero_w;
  assign flag_carry = flags_q.carry;
  assign flag_zero  = flags_q.zero;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         sub_en,
  input logic         bus_oe,
  input logic         flag_load,
  input logic [W-1:0] bus_data,
  input logic         bus_valid,
  input logic         carry_out,
  input logic         zero_out,
  input logic         flag_carry,
  input logic         flag_zero,
  input logic [W-1:0] sum_w
);
  logic [W:0]   wide_add;
  logic [W-1:0] diff;
  assign wide_add = {1'b0, opa} + {1'b0, opb};
  assign diff     = opa - opb;

  assert_add_R1: assert property (@(posedge clk) disable iff (rst)
    !sub_en |-> sum_w == wide_add[W-1:0]);

  assert_sub_R2: assert property (@(posedge clk) disable iff (rst)
    sub_en |-> sum_w == diff);

  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    carry_out == (sub_en ? (opa >= opb) : wide_add[W]));

  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    zero_out == (sum_w == '0));

  assert_bus_R5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (bus_valid && bus_data == sum_w));

  assert_idle_bus_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (!bus_valid && bus_data == '0));

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    flag_load |=> (flag_carry == $past(carry_out) && flag_zero == $past(zero_out)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !flag_load |=> ($stable(flag_carry) && $stable(flag_zero)));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!flag_carry && !flag_zero));
endmodule

bind addsub_flags_unit addsub_flags_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .opa        (opa),
  .opb        (opb),
  .sub_en     (sub_en),
  .bus_oe     (bus_oe),
  .flag_load  (flag_load),
  .bus_data   (bus_data),
  .bus_valid  (bus_valid),
  .carry_out  (carry_out),
  .zero_out   (zero_out),
  .flag_carry (flag_carry),
  .flag_zero  (flag_zero),
  .sum_w      (sum_w)
);

// File: tb/test_addsub_flags_unit.sv
module test_addsub_flags_unit;
  localparam int W     = 8;
  localparam int CLK_P = 10;

  typedef struct {
    logic [W-1:0] data;
    logic         valid;
    logic         c;
    logic         z;
    logic         fc;
    logic         fz;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         sub_en = 1'b0;
  logic         bus_oe = 1'b0;
  logic         flag_load = 1'b0;
  logic [W-1:0] bus_data;
  logic         bus_valid;
  logic         carry_out;
  logic         zero_out;
  logic         flag_carry;
  logic         flag_zero;

  int   n_checks = 0;
  int   n_bad    = 0;
  bit   finished = 1'b0;
  exp_t sb[$];
  logic m_fc = 1'b0;
  logic m_fz = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  addsub_flags_unit #(.W(W)) i_addsub_flags_unit (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .sub_en(sub_en),
    .bus_oe(bus_oe), .flag_load(flag_load), .bus_data(bus_data),
    .bus_valid(bus_valid), .carry_out(carry_out), .zero_out(zero_out),
    .flag_carry(flag_carry), .flag_zero(flag_zero)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply stimulus at negedge, push the expected outcome
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic s, input logic oe, input logic ld, input string tag);
    exp_t e;
    logic [W-1:0] res;
    logic         c;
    @(negedge clk);
    rst = r; opa = a; opb = b; sub_en = s; bus_oe = oe; flag_load = ld;
    if (s) begin
      res = a - b;           // R2 difference
      c   = (a >= b);        // R3 no borrow
    end else begin
      res = a + b;           // R1 sum
      c   = (int'(a) + int'(b)) >= (1 << W);
    end
    if (r) begin m_fc = 1'b0; m_fz = 1'b0; end          // R8
    else if (ld) begin m_fc = c; m_fz = (res == 0); end // R6, R9
    e.data  = oe ? res : '0;
    e.valid = oe;
    e.c     = c;
    e.z     = (res == 0);
    e.fc    = m_fc;
    e.fz    = m_fz;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // monitor: after each edge compare the item pushed before it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R5 bus_data"}, int'(bus_data), int'(e.data));
        check({e.tag, " R5 bus_valid"}, int'(bus_valid), int'(e.valid));
        check({e.tag, " R3 carry_out"}, int'(carry_out), int'(e.c));
        check({e.tag, " R4 zero_out"}, int'(zero_out), int'(e.z));
        check({e.tag, " R6/R7/R8 flag_carry"}, int'(flag_carry), int'(e.fc));
        check({e.tag, " R6/R7/R8 flag_zero"}, int'(flag_zero), int'(e.fz));
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    // R8: reset wins over load, reset state
    step(1, 8'h00, 8'h00, 0, 0, 1, "R8 reset with load");
    step(1, 8'hFF, 8'h01, 0, 0, 1, "R8 reset state");
    // R9: bus drive and flag load together on the corner cases
    step(0, 8'h00, 8'h00, 1, 1, 1, "R2 R9 0-0");
    step(0, 8'hFF, 8'h01, 0, 1, 1, "R1 R9 FF+1");
    step(0, 8'h05, 8'h06, 1, 1, 1, "R2 R9 5-6");
    step(0, 8'h03, 8'h04, 0, 1, 1, "R1 3+4");
    step(0, 8'h80, 8'h80, 0, 0, 1, "R1 R3 80+80");
    step(0, 8'hA5, 8'h5A, 1, 1, 1, "R2 R3 A5-5A");
    // R7: flags hold while load is low
    step(0, 8'h00, 8'h00, 0, 1, 1, "R6 set zero");
    step(0, 8'h12, 8'h34, 0, 1, 0, "R7 hold add");
    step(0, 8'h01, 8'h02, 1, 0, 0, "R7 hold sub");
    step(0, 8'hFF, 8'hFF, 0, 1, 0, "R7 hold carry");
    step(1, 8'h07, 8'h07, 1, 1, 1, "R8 mid reset");
    // R1/R2 sweep over pseudo-random operands
    lf = 8'h5B;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] b;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      b  = lf ^ 8'(i * 37);
      step(0, lf, b, i[0], i[1] | i[2], i[3] | i[0], "R1 R2 sweep");
    end
    step(0, 8'h00, 8'h00, 0, 0, 0, "final");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule